// File: doc/BRIEF.md
# Microcoded LED PWM Channel Sequencer

This block is one PWM lighting channel whose duty cycle is driven by a small stored program rather than by a fixed register. An 8-bit brightness level is compared against an 8-bit reference count that runs freely on a slow base-clock enable. The program can set the level outright, ramp it up or down over a timed span, loop with four hardware loop counters, raise an end-of-sequence pulse to a host, and meet other channels through a three-line trigger bus.

The instruction memory sits outside the block. Its read port is asynchronous: the program counter drives the address, and the word is read in the same cycle. All program progress happens only in cycles where `tick_i` is high. Setting `en_i` low holds the channel in a cleared state, which is when the memory is meant to be reloaded.

Top module: `pwm_seq_channel`

## Requirements
- R1: The reference count goes up by one on each tick and wraps from 255 to 0. `pwm_o` is high exactly when the reference is strictly greater than the brightness level. While the channel is halted, the reference is 0 and the level is 255.
- R2: `imem_addr_o` is the program counter. When the channel is idle, at most one instruction executes per tick, and nothing advances in a cycle without a tick.
- R3: With bit 15 at 0 and bits 13:0 equal to 0x007F, the level is set to 255. With bits 13:0 equal to 0x00FF, the level is set to 0. With bits 13:0 equal to 0, the program counter is set to 0. Bit 14 is ignored in all three words.
- R4: Any other word with bit 15 at 0 is a ramp. Bits 6:0 hold the increment, bit 7 the direction (1 = down), bits 13:8 the step time and bit 14 the prescale. When the step time is 0, the increment is added or subtracted at once, saturating at 0 and 255, and the program counter advances.
- R5: A ramp with a nonzero step time S and increment N uses a divider D of 16 (bit 14 = 0) or 512 (bit 14 = 1). The level moves by one every S·D ticks, saturating at the bounds. The program counter advances on the tick of the N-th move.
- R6: Bits 15:13 = 101 mark a branch. Bits 12:11 pick a loop counter, bits 10:7 give a count C, bit 6 selects relative (1) or absolute (0), and bits 5:0 give a distance or target. Relative distance 0 is a no-op. C = 0 always jumps. Otherwise the branch jumps and increments the selected counter until the counter equals C; it then clears the counter and falls through. The four counters are independent.
- R7: Bits 15:13 = 110 mark an end. Bit 12 gives a one-cycle `end_irq_o` pulse in the cycle after the tick. Bit 11 sets the program counter to 0 and the level to 255; without bit 11 the counter advances.
- R8: Bits 15:13 = 111 mark a trigger. Bits 9:7 are the wait mask and bits 3:1 the send mask (bit i+7 or i+1 refers to channel i). Incoming `trig_in_i` pulses are latched per source until consumed. When every waited source is latched, those latches clear, `trig_out_o` pulses the send mask for one cycle after the tick, and the program counter advances. Otherwise the instruction stalls.
- R9: Bits 15:13 = 100 is invalid, and so is a ramp word with increment 0 or 127 other than the fixed words of R3. Executing one sets `invalid_o` and holds the channel halted until `en_i` goes low.
- R10: With `en_i` low or after reset, the program counter, loop counters, ramp state and latched triggers are zero, `invalid_o` is 0 and `pwm_o` is low.
- R11: The program counter wraps from 63 to 0 when it advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base-clock enable; all sequencing steps on it |
| en_i | input | 1 | Channel run enable; low holds the channel cleared |
| imem_addr_o | output | 6 | Instruction memory read address |
| imem_data_i | input | 16 | Instruction word at `imem_addr_o` |
| trig_in_i | input | 3 | Trigger pulses from channels 0..2 |
| trig_out_o | output | 3 | Trigger pulses to channels 0..2 |
| pwm_o | output | 1 | PWM output |
| end_irq_o | output | 1 | One-cycle end-of-sequence pulse |
| invalid_o | output | 1 | Invalid-instruction flag |

## Verification
The hardest states to reach are two nested branches that share the stepping of separate loop counters, and a wait instruction whose trigger arrived many cycles before, possibly together with other sources. The stimulus reaches both through short programs. In one, an inner relative loop sits inside an outer absolute loop. In the other, trigger pulses from several sources arrive on co-prime periods, so latches build up before, during and after the waits. A behavioural model tracks every tick, so each of these interleavings is compared on every clock.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;
  localparam int unsigned N_TRIG = 3;

  typedef enum logic [2:0] {
    K_RAMP, K_SMAX, K_SMIN, K_GTS, K_BRANCH, K_END, K_TRIG, K_BAD
  } kind_e;

  function automatic kind_e decode(input logic [15:0] w);
    kind_e k;
    if (!w[15]) begin
      if (w[13:0] == 14'h007F)                   k = K_SMAX;
      else if (w[13:0] == 14'h00FF)              k = K_SMIN;
      else if (w[13:0] == 14'h0000)              k = K_GTS;
      else if (w[6:0] == 7'd0 || w[6:0] == 7'h7F) k = K_BAD;
      else                                        k = K_RAMP;
    end else begin
      unique case (w[14:13])
        2'b01:   k = K_BRANCH;
        2'b10:   k = K_END;
        2'b11:   k = K_TRIG;
        default: k = K_BAD;
      endcase
    end
    return k;
  endfunction
endpackage

// File: rtl/pwm_seq_refcmp.sv
module pwm_seq_refcmp #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] level_i,
  output logic         pwm_o
);
  logic [W-1:0] ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ref_q <= '0;
    else if (clr_i)  ref_q <= '0;
    else if (tick_i) ref_q <= ref_q + 1'b1;
  end

  assign pwm_o = ref_q > level_i;

  p_ref_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && tick_i && ref_q == '1) |=> ref_q == '0);
endmodule

// File: rtl/pwm_seq_ramp.sv
module pwm_seq_ramp #(
  parameter int unsigned DIV_LO = 16,
  parameter int unsigned DIV_HI = 512,
  parameter int unsigned INC_W  = 7,
  parameter int unsigned STEP_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [INC_W-1:0]  units_i,
  input  logic [STEP_W-1:0] len_i,
  input  logic              slow_i,
  input  logic              down_i,
  output logic              busy_o,
  output logic              down_o,
  output logic              step_o,
  output logic              last_o
);
  localparam int unsigned PRE_W = $clog2(DIV_HI);

  logic              busy_q, down_q, slow_q;
  logic [INC_W-1:0]  left_q;
  logic [STEP_W-1:0] len_q, stp_q;
  logic [PRE_W-1:0]  pre_q;
  logic              pre_end, stp_end;

  assign pre_end = pre_q == (slow_q ? PRE_W'(DIV_HI - 1) : PRE_W'(DIV_LO - 1));
  assign stp_end = stp_q == (len_q - STEP_W'(1));
  assign step_o  = busy_q & tick_i & pre_end & stp_end;
  assign last_o  = step_o & (left_q == INC_W'(1));
  assign busy_o  = busy_q;
  assign down_o  = down_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; down_q <= 1'b0; slow_q <= 1'b0;
      left_q <= '0; len_q <= '0; stp_q <= '0; pre_q <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0; left_q <= '0; stp_q <= '0; pre_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1; left_q <= units_i; len_q <= len_i;
      slow_q <= slow_i; down_q <= down_i; stp_q <= '0; pre_q <= '0;
    end else if (busy_q && tick_i) begin
      if (pre_end) begin
        pre_q <= '0;
        if (stp_end) begin
          stp_q  <= '0;
          left_q <= left_q - 1'b1;
          if (left_q == INC_W'(1)) busy_q <= 1'b0;
        end else begin
          stp_q <= stp_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  p_start_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  p_left_nz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (left_q != '0 && len_q != '0));
endmodule

// File: rtl/pwm_seq_loops.sv
module pwm_seq_loops #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             at_limit_o
);
  localparam int unsigned N = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q [N];

  assign at_limit_o = cnt_q[sel_i] == limit_i;

  for (genvar g = 0; g < N; g++) begin : g_lc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q[g] <= '0;
      else if (clr_i)  cnt_q[g] <= '0;
      else if (hit_i && sel_i == SEL_W'(g))
        cnt_q[g] <= at_limit_o ? '0 : cnt_q[g] + 1'b1;
    end

    p_wrap_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_i && sel_i == SEL_W'(g) && at_limit_o) |=> cnt_q[g] == '0);
    p_count_up_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_i && sel_i == SEL_W'(g) && !at_limit_o) |=> cnt_q[g] == $past(cnt_q[g]) + 1'b1);
  end
endmodule

// File: rtl/pwm_seq_trig.sv
module pwm_seq_trig #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] in_i,
  input  logic [N-1:0] take_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= '0;
    else if (clr_i) pend_q <= '0;
    else            pend_q <= (pend_q & ~take_i) | in_i;
  end

  assign pend_o = pend_q;

  p_latch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (pend_q & $past(in_i)) == $past(in_i));
  p_take_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i & ~pend_q) == '0);
endmodule

// File: rtl/pwm_seq_channel.sv
module pwm_seq_channel
  import pwm_seq_pkg::*;
#(
  parameter int unsigned PC_W   = 6,
  parameter int unsigned LVL_W  = 8,
  parameter int unsigned DIV_LO = 16,
  parameter int unsigned DIV_HI = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  output logic [PC_W-1:0]   imem_addr_o,
  input  logic [15:0]       imem_data_i,
  input  logic [N_TRIG-1:0] trig_in_i,
  output logic [N_TRIG-1:0] trig_out_o,
  output logic              pwm_o,
  output logic              end_irq_o,
  output logic              invalid_o
);
  localparam int unsigned INC_W  = 7;
  localparam int unsigned STEP_W = 6;
  localparam int unsigned LSEL_W = 2;
  localparam int unsigned LCNT_W = 4;
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  logic [PC_W-1:0]   pc_q, pc_d, pc_inc, br_tgt;
  logic [LVL_W-1:0]  lvl_q, lvl_d, lvl_imm;
  logic [LVL_W:0]    up_sum;
  logic              inv_q, irq_q;
  logic [N_TRIG-1:0] tout_q, pend, take;
  kind_e             kind;
  logic              halt, exec, bad, clr;
  logic              r_busy, r_down, r_step, r_last, r_start;
  logic              lc_hit, lc_at, br_nop, trig_ok;

  // field views
  logic [INC_W-1:0]  f_inc;
  logic [STEP_W-1:0] f_len, f_dist;
  logic [LSEL_W-1:0] f_sel;
  logic [LCNT_W-1:0] f_cnt;
  logic [N_TRIG-1:0] f_wait, f_send;

  assign f_inc  = imem_data_i[6:0];
  assign f_len  = imem_data_i[13:8];
  assign f_sel  = imem_data_i[12:11];
  assign f_cnt  = imem_data_i[10:7];
  assign f_dist = imem_data_i[5:0];
  assign f_wait = imem_data_i[9:7];
  assign f_send = imem_data_i[3:1];

  assign kind    = decode(imem_data_i);
  assign halt    = !en_i || inv_q;
  assign exec    = tick_i && !halt && !r_busy;
  assign bad     = exec && kind == K_BAD;
  assign clr     = halt || bad;
  assign pc_inc  = pc_q + 1'b1;
  assign br_nop  = imem_data_i[6] && f_dist == '0;
  assign br_tgt  = imem_data_i[6] ? pc_q - PC_W'(f_dist) : PC_W'(f_dist);
  assign lc_hit  = exec && kind == K_BRANCH && f_cnt != '0 && !br_nop;
  assign trig_ok = (pend & f_wait) == f_wait;
  assign take    = (exec && kind == K_TRIG && trig_ok) ? f_wait : '0;
  assign r_start = exec && kind == K_RAMP && f_len != '0;

  assign up_sum  = {1'b0, lvl_q} + (LVL_W+1)'(f_inc);
  always_comb begin
    if (imem_data_i[7])
      lvl_imm = ({1'b0, lvl_q} < (LVL_W+1)'(f_inc)) ? '0 : lvl_q - LVL_W'(f_inc);
    else
      lvl_imm = up_sum[LVL_W] ? LVL_MAX : up_sum[LVL_W-1:0];
  end

  always_comb begin
    pc_d  = pc_q;
    lvl_d = lvl_q;
    if (tick_i && !halt && r_busy) begin
      if (r_step)
        lvl_d = r_down ? ((lvl_q == '0) ? lvl_q : lvl_q - 1'b1)
                       : ((lvl_q == LVL_MAX) ? lvl_q : lvl_q + 1'b1);
      if (r_last) pc_d = pc_inc;
    end else if (exec) begin
      unique case (kind)
        K_RAMP: if (f_len == '0) begin lvl_d = lvl_imm; pc_d = pc_inc; end
        K_SMAX: begin lvl_d = LVL_MAX; pc_d = pc_inc; end
        K_SMIN: begin lvl_d = '0; pc_d = pc_inc; end
        K_GTS:  pc_d = '0;
        K_BRANCH: begin
          if (br_nop)              pc_d = pc_inc;
          else if (f_cnt == '0)    pc_d = br_tgt;
          else if (lc_at)          pc_d = pc_inc;
          else                     pc_d = br_tgt;
        end
        K_END: begin
          if (imem_data_i[11]) begin pc_d = '0; lvl_d = LVL_MAX; end
          else pc_d = pc_inc;
        end
        K_TRIG: if (trig_ok) pc_d = pc_inc;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0; lvl_q <= LVL_MAX; inv_q <= 1'b0; irq_q <= 1'b0; tout_q <= '0;
    end else begin
      irq_q  <= exec && kind == K_END && imem_data_i[12];
      tout_q <= (exec && kind == K_TRIG && trig_ok) ? f_send : '0;
      if (!en_i)    inv_q <= 1'b0;
      else if (bad) inv_q <= 1'b1;
      if (clr) begin
        pc_q <= '0; lvl_q <= LVL_MAX;
      end else begin
        pc_q <= pc_d; lvl_q <= lvl_d;
      end
    end
  end

  pwm_seq_refcmp #(.W(LVL_W)) i_refcmp (
    .clk_i, .rst_ni, .clr_i(clr), .tick_i, .level_i(lvl_q), .pwm_o
  );

  pwm_seq_ramp #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .INC_W(INC_W), .STEP_W(STEP_W)) i_ramp (
    .clk_i, .rst_ni, .clr_i(clr), .tick_i, .start_i(r_start),
    .units_i(f_inc), .len_i(f_len), .slow_i(imem_data_i[14]), .down_i(imem_data_i[7]),
    .busy_o(r_busy), .down_o(r_down), .step_o(r_step), .last_o(r_last)
  );

  pwm_seq_loops #(.SEL_W(LSEL_W), .CNT_W(LCNT_W)) i_loops (
    .clk_i, .rst_ni, .clr_i(clr), .hit_i(lc_hit), .sel_i(f_sel),
    .limit_i(f_cnt), .at_limit_o(lc_at)
  );

  pwm_seq_trig #(.N(N_TRIG)) i_trig (
    .clk_i, .rst_ni, .clr_i(clr), .in_i(trig_in_i), .take_i(take), .pend_o(pend)
  );

  assign imem_addr_o = pc_q;
  assign end_irq_o   = irq_q;
  assign trig_out_o  = tout_q;
  assign invalid_o   = inv_q;

  p_halt_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (imem_addr_o == '0 && !invalid_o && !pwm_o));
  p_max_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q == LVL_MAX |-> !pwm_o);
  p_inv_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (invalid_o && en_i) |=> invalid_o);
  p_irq_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_irq_o |-> $past(tick_i));
  p_ramp_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !inv_q && r_busy && !r_last) |=> imem_addr_o == $past(imem_addr_o));
endmodule

// File: tb/test_pwm_seq_channel.sv
module test_pwm_seq_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  trig_in = 3'b000;
  logic [5:0]  addr;
  logic [15:0] data;
  logic [2:0]  tout;
  logic        pwm, irq, inv;
  logic [15:0] mem [64];

  assign data = mem[addr];
  always #5 clk = ~clk;

  pwm_seq_channel i_pwm_seq_channel (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .en_i(en),
    .imem_addr_o(addr), .imem_data_i(data),
    .trig_in_i(trig_in), .trig_out_o(tout),
    .pwm_o(pwm), .end_irq_o(irq), .invalid_o(inv)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;
  string phase = "R10";

  // behavioural reference
  int       m_pc, m_br, m_ref, m_units, m_per, m_cnt;
  int       m_lc [4];
  bit       m_busy, m_dn, m_inv, m_irq;
  bit [2:0] m_pend, m_tout;

  task automatic m_clear();
    m_pc = 0; m_br = 255; m_ref = 0; m_busy = 0; m_units = 0; m_cnt = 0;
    m_per = 0; m_dn = 0; m_pend = 0;
    for (int k = 0; k < 4; k++) m_lc[k] = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    logic [15:0] w;
    bit          bad;
    bit [2:0]    take;
    int          tgt, sel, cntf, d, inc;
    if (!rst_n) begin
      m_clear(); m_inv = 0; m_irq = 0; m_tout = 0;
    end else begin
      m_irq = 0; m_tout = 0; bad = 0; take = 0;
      if (!en) begin
        m_clear(); m_inv = 0;
      end else if (m_inv) begin
        m_clear();
      end else begin
        if (tick) begin
          if (m_busy) begin
            m_cnt++;
            if (m_cnt == m_per) begin
              m_cnt = 0;
              if (m_dn) m_br = (m_br > 0) ? m_br - 1 : 0;
              else      m_br = (m_br < 255) ? m_br + 1 : 255;
              m_units--;
              if (m_units == 0) begin m_busy = 0; m_pc = (m_pc + 1) % 64; end
            end
          end else begin
            w = mem[m_pc];
            if (!w[15]) begin
              inc = int'(w[6:0]);
              if (w[13:0] == 14'h007F)      begin m_br = 255; m_pc = (m_pc + 1) % 64; end
              else if (w[13:0] == 14'h00FF) begin m_br = 0;   m_pc = (m_pc + 1) % 64; end
              else if (w[13:0] == 14'h0)    m_pc = 0;
              else if (inc == 0 || inc == 127) bad = 1;
              else if (w[13:8] == 6'd0) begin
                m_br = w[7] ? ((m_br - inc < 0) ? 0 : m_br - inc)
                            : ((m_br + inc > 255) ? 255 : m_br + inc);
                m_pc = (m_pc + 1) % 64;
              end else begin
                m_busy = 1; m_units = inc; m_cnt = 0; m_dn = w[7];
                m_per = int'(w[13:8]) * (w[14] ? 512 : 16);
              end
            end else begin
              case (w[14:13])
                2'b00: bad = 1;
                2'b01: begin
                  sel = int'(w[12:11]); cntf = int'(w[10:7]); d = int'(w[5:0]);
                  tgt = w[6] ? (m_pc - d + 64) % 64 : d;
                  if (w[6] && d == 0)            m_pc = (m_pc + 1) % 64;
                  else if (cntf == 0)            m_pc = tgt;
                  else if (m_lc[sel] == cntf) begin m_lc[sel] = 0; m_pc = (m_pc + 1) % 64; end
                  else begin m_lc[sel]++; m_pc = tgt; end
                end
                2'b10: begin
                  m_irq = w[12];
                  if (w[11]) begin m_pc = 0; m_br = 255; end
                  else m_pc = (m_pc + 1) % 64;
                end
                default: begin
                  if ((m_pend & w[9:7]) == w[9:7]) begin
                    take = w[9:7]; m_tout = w[3:1]; m_pc = (m_pc + 1) % 64;
                  end
                end
              endcase
            end
          end
          m_ref = (m_ref + 1) % 256;
        end
        if (bad) begin m_clear(); m_inv = 1; end
        else m_pend = (m_pend & ~take) | trig_in;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [%s] %s actual=%0d expected=%0d", req, phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(pwm == (m_ref > m_br), "R1", "pwm_o", int'(pwm), int'(m_ref > m_br));
      chk(int'(addr) == m_pc, "R2", "imem_addr_o", int'(addr), m_pc);
      chk(irq == m_irq, "R7", "end_irq_o", int'(irq), int'(m_irq));
      chk(tout == m_tout, "R8", "trig_out_o", int'(tout), int'(m_tout));
      chk(inv == m_inv, "R9", "invalid_o", int'(inv), int'(m_inv));
    end
  end

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_up();
    end
  end

  task automatic run(input int n, input bit slow_tick, input bit trig_on);
    for (int i = 0; i < n; i++) begin
      tick = slow_tick ? (i % 3 == 0) : 1'b1;
      if (trig_on)
        trig_in = (i % 7 == 0) ? 3'b010 : (i % 11 == 3) ? 3'b101 : (i % 13 == 5) ? 3'b111 : 3'b000;
      else
        trig_in = 3'b000;
      @(negedge clk);
    end
    tick = 1'b0;
    trig_in = 3'b000;
  endtask

  // R10: disable clears the channel
  task automatic stop_ch();
    en = 1'b0; tick = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(addr == 6'd0, "R10", "addr after disable", int'(addr), 0);
    chk(inv == 1'b0, "R10", "invalid after disable", int'(inv), 0);
    chk(pwm == 1'b0, "R10", "pwm after disable", int'(pwm), 0);
    for (int k = 0; k < 64; k++) mem[k] = 16'h0000;
  endtask

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 16'h0000;
    repeat (3) @(negedge clk);
    chk(addr == 6'd0, "R10", "reset addr", int'(addr), 0);
    chk(pwm == 1'b0, "R10", "reset pwm", int'(pwm), 0);
    chk(inv == 1'b0, "R10", "reset invalid", int'(inv), 0);
    chk(irq == 1'b0, "R10", "reset irq", int'(irq), 0);
    chk(tout == 3'b000, "R10", "reset trig_out", int'(tout), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3, R2: fixed words, bit 14 set on set-min, gated ticks
    phase = "R3";
    mem[0] = 16'h007F; mem[1] = 16'h40FF; mem[2] = 16'h0000;
    en = 1'b1;
    run(400, 1'b0, 1'b0);
    run(600, 1'b1, 1'b0);
    stop_ch();

    // R4 immediate ramps with saturation, R5 timed ramps both prescales
    phase = "R4 R5";
    mem[0] = 16'h00FF; mem[1] = 16'h0064; mem[2] = 16'h0064; mem[3] = 16'h0064;
    mem[4] = 16'h0285; mem[5] = 16'h4102; mem[6] = 16'h00E4; mem[7] = 16'h00E4;
    mem[8] = 16'h0303; mem[9] = 16'h0000;
    en = 1'b1;
    run(2900, 1'b0, 1'b0);
    stop_ch();

    // R6: nested loops, relative no-op, forever jump
    phase = "R6";
    mem[0] = 16'h00FF; mem[1] = 16'h000A; mem[2] = 16'hA141; mem[3] = 16'h0001;
    mem[4] = 16'hA881; mem[5] = 16'hA1C0; mem[6] = 16'hB808; mem[7] = 16'h8000;
    mem[8] = 16'hD800;
    en = 1'b1;
    run(500, 1'b0, 1'b0);
    stop_ch();

    // R7 end variants, R8 trigger latching and handshakes
    phase = "R7 R8";
    mem[0] = 16'hE00A; mem[1] = 16'hE100; mem[2] = 16'hD000; mem[3] = 16'hE28C;
    mem[4] = 16'hD800;
    en = 1'b1;
    run(700, 1'b0, 1'b1);
    run(300, 1'b1, 1'b1);
    stop_ch();

    // R11: program counter wrap
    phase = "R11";
    mem[0] = 16'hA03E; mem[62] = 16'h0001; mem[63] = 16'h0002;
    en = 1'b1;
    run(300, 1'b0, 1'b0);
    stop_ch();

    // R9: invalid opcode, zero increment, 127 increment with step time
    phase = "R9";
    mem[0] = 16'h0005; mem[1] = 16'h8123;
    en = 1'b1;
    run(40, 1'b0, 1'b0);
    chk(inv == 1'b1, "R9", "invalid after opcode 100", int'(inv), 1);
    chk(addr == 6'd0, "R9", "addr held while invalid", int'(addr), 0);
    chk(pwm == 1'b0, "R9", "pwm held low while invalid", int'(pwm), 0);
    stop_ch();
    mem[0] = 16'h0300;
    en = 1'b1;
    run(20, 1'b0, 1'b0);
    chk(inv == 1'b1, "R9", "invalid after zero increment", int'(inv), 1);
    stop_ch();
    mem[0] = 16'h017F;
    en = 1'b1;
    run(20, 1'b0, 1'b0);
    chk(inv == 1'b1, "R9", "invalid after increment 127", int'(inv), 1);
    stop_ch();

    // R10: disable in the middle of a timed ramp, then restart
    phase = "R10";
    mem[0] = 16'h00FF; mem[1] = 16'h0F05; mem[2] = 16'h0000;
    en = 1'b1;
    run(120, 1'b0, 1'b0);
    stop_ch();
    mem[0] = 16'h00FF; mem[1] = 16'h0F05; mem[2] = 16'h0000;
    en = 1'b1;
    run(200, 1'b0, 1'b0);
    stop_ch();

    finish_up();
  end
endmodule